// File: doc/BRIEF.md
# Interpolated Half-Sine Modulation Oscillator

This block produces a slow sine-shaped modulation word that sets the read delay of a sweeping delay-line effect. A wide phase accumulator steps forward by a rate word once per audio sample strobe. Only one half-cycle of a sine is stored; the second half is obtained by flipping the sign, so the table can stay small and still span a full cycle.

Between two neighbouring table points the block interpolates linearly, using the accumulator's low half as a fine phase fraction. This gives smooth output at rates well below one table step per sample. The signed wave is shifted into the unsigned range and then multiplied by a depth byte. The result is a fixed-point delay offset with an integer byte and a fraction byte. The integer byte never exceeds the depth.

Top module: `hsine_lfo`

## Requirements
- R1: While reset is asserted, `mod_out` is 0. After reset the phase is 0 and the held depth is 0x0D, so the first output after release is 0x0680.
- R2: On each clock where `strobe` is high, the 32-bit phase grows by `rate` (zero-extended). Carries out of the low 16 bits ripple into the upper 16 bits. The phase advances exactly once per strobed cycle.
- R3: When `strobe` is low, neither the phase nor the held depth changes, whatever `rate` and `depth` carry. `mod_out` therefore stays constant.
- R4: The `depth` input is captured into the held depth only on a strobed cycle.
- R5: Table entry i (0..511) equals round(32767·sin(π·i/512)). The first sample's index is bits [8:0] of the phase's upper half (phase[24:16]).
- R6: Bit 9 of the upper phase half (phase[25]) sets polarity. When it is 0 the table value is negated; when it is 1 the value is used unchanged.
- R7: The second sample is taken at the upper phase half plus one. Both its index and its polarity come from that incremented value.
- R8: With fraction f = phase[15:0], the wave is floor((s0·(65535−f) + s1·f) / 65536) as a signed 16-bit value.
- R9: The unsigned wave u = wave + 0x8000 (mod 2^16) gives `mod_out` = (u·depth) >> 8. A held depth of 0 gives 0, and `mod_out`>>8 never exceeds the held depth.
- R10: `mod_out` is registered. It reflects the phase and depth held after a strobe edge from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | One-cycle sample tick; advances the phase and captures depth |
| rate | input | 16 | Phase increment per tick |
| depth | input | 8 | Modulation depth, captured on a tick |
| mod_out | output | 16 | Scaled modulation value, integer byte over fraction byte |

## Verification
The bench builds the block with its default sizes: a 512-entry table, a 32-bit phase and an 8-bit depth. At these sizes a rate of 0xFFFF moves the table index by about one step per tick, so about 1100 ticks cover every index under both polarities and pass through the half-cycle and full-cycle wraps. A rate of 0x8000 alternates the fraction between 0 and one half, which exposes raw table values and the second-sample path. Rates with odd low bits, together with depths cycling through the full byte range including 0 and 0xFF, exercise carry ripple, rounding of the interpolation and the scaling bound.

// File: rtl/lfo_pkg.sv
package lfo_pkg;

   // Rounded amplitude of a half-sine point i out of 2**idx_w, evaluated
   // at elaboration with a folded Taylor series.
   function automatic int sine_entry(input int i, input int idx_w, input int amp);
      real pi_c;
      real x;
      real term;
      real acc;
      pi_c = 3.14159265358979323846;
      x    = pi_c * real'(i) / real'(1 << idx_w);
      if (x > pi_c / 2.0) x = pi_c - x;
      term = x;
      acc  = x;
      for (int k = 1; k < 14; k++) begin
         term = -term * x * x / real'((2 * k) * (2 * k + 1));
         acc  = acc + term;
      end
      return $rtoi(acc * real'(amp) + 0.5);
   endfunction

endpackage

// File: rtl/lfo_phase_acc.sv
module lfo_phase_acc #(
   parameter int FRAC_W = 16,
   parameter int INT_W  = 16,
   parameter int VIEW_W = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic [FRAC_W-1:0] rate,
   output logic [VIEW_W-1:0] phase_view
);
   localparam int PHASE_W = FRAC_W + INT_W;

   if (VIEW_W > PHASE_W) begin : g_bad_view
      $error("lfo_phase_acc: view wider than accumulator");
   end

   logic [PHASE_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (step_en) begin
         acc_q <= acc_q + PHASE_W'(rate);
      end
   end

   assign phase_view = acc_q[VIEW_W-1:0];
endmodule

// File: rtl/hsine_rom.sv
module hsine_rom #(
   parameter int IDX_W  = 9,
   parameter int SAMP_W = 16
) (
   input  logic [IDX_W-1:0]  idx_a,
   input  logic [IDX_W-1:0]  idx_b,
   output logic [SAMP_W-1:0] mag_a,
   output logic [SAMP_W-1:0] mag_b
);
   localparam int N_ENT = 1 << IDX_W;
   localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

   logic [SAMP_W-1:0] tbl [N_ENT];

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      localparam int VAL = lfo_pkg::sine_entry(i, IDX_W, AMP);
      assign tbl[i] = SAMP_W'(VAL);
   end

   assign mag_a = tbl[idx_a];
   assign mag_b = tbl[idx_b];
endmodule

// File: rtl/lfo_interp.sv
module lfo_interp #(
   parameter int FRAC_W = 16,
   parameter int IDX_W  = 9,
   parameter int SAMP_W = 16
) (
   input  logic [IDX_W:0]            whole,
   input  logic [FRAC_W-1:0]         frac,
   output logic [IDX_W-1:0]          idx_a,
   output logic [IDX_W-1:0]          idx_b,
   input  logic [SAMP_W-1:0]         mag_a,
   input  logic [SAMP_W-1:0]         mag_b,
   output logic signed [SAMP_W-1:0]  wave
);
   localparam int PROD_W = SAMP_W + FRAC_W + 1;
   localparam int SUM_W  = PROD_W + 1;

   logic [IDX_W:0]             pt   [2];
   logic [SAMP_W-1:0]          mag  [2];
   logic [FRAC_W-1:0]          wt   [2];
   logic signed [SAMP_W-1:0]   smp  [2];
   logic signed [PROD_W-1:0]   prod [2];
   logic signed [SUM_W-1:0]    sum;

   assign pt[0]  = whole;
   assign pt[1]  = whole + (IDX_W + 1)'(1);
   assign mag[0] = mag_a;
   assign mag[1] = mag_b;
   assign wt[0]  = ~frac;
   assign wt[1]  = frac;
   assign idx_a  = pt[0][IDX_W-1:0];
   assign idx_b  = pt[1][IDX_W-1:0];

   for (genvar l = 0; l < 2; l++) begin : g_lane
      // polarity bit low selects the negative half-cycle
      assign smp[l]  = pt[l][IDX_W] ? $signed(mag[l]) : -$signed(mag[l]);
      assign prod[l] = PROD_W'(smp[l]) * $signed({1'b0, wt[l]});
   end

   assign sum  = SUM_W'(prod[0]) + SUM_W'(prod[1]);
   assign wave = SAMP_W'(sum >>> FRAC_W);
endmodule

// File: rtl/lfo_depth_scale.sv
module lfo_depth_scale #(
   parameter int SAMP_W  = 16,
   parameter int DEPTH_W = 8
) (
   input  logic signed [SAMP_W-1:0] wave,
   input  logic [DEPTH_W-1:0]       depth,
   output logic [SAMP_W-1:0]        scaled
);
   localparam int PROD_W = SAMP_W + DEPTH_W;

   logic [SAMP_W-1:0] uwave;
   logic [PROD_W-1:0] prod;

   // adding half scale is a flip of the sign bit
   assign uwave  = {~wave[SAMP_W-1], wave[SAMP_W-2:0]};
   assign prod   = PROD_W'(uwave) * PROD_W'(depth);
   assign scaled = SAMP_W'(prod >> DEPTH_W);
endmodule

// File: rtl/hsine_lfo.sv
module hsine_lfo #(
   parameter int                 FRAC_W    = 16,
   parameter int                 INT_W     = 16,
   parameter int                 IDX_W     = 9,
   parameter int                 SAMP_W    = 16,
   parameter int                 DEPTH_W   = 8,
   parameter logic [DEPTH_W-1:0] DEPTH_RST = 8'h0D
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strobe,
   input  logic [FRAC_W-1:0]  rate,
   input  logic [DEPTH_W-1:0] depth,
   output logic [SAMP_W-1:0]  mod_out
);
   localparam int VIEW_W = FRAC_W + IDX_W + 1;

   if (INT_W < IDX_W + 1) begin : g_bad_int
      $error("hsine_lfo: upper phase too narrow for index and polarity");
   end
   if (SAMP_W < 2 || DEPTH_W < 1 || DEPTH_W > SAMP_W) begin : g_bad_width
      $error("hsine_lfo: unsupported sample or depth width");
   end

   logic [VIEW_W-1:0]        phase_view;
   logic [DEPTH_W-1:0]       depth_q;
   logic [IDX_W-1:0]         idx_a;
   logic [IDX_W-1:0]         idx_b;
   logic [SAMP_W-1:0]        mag_a;
   logic [SAMP_W-1:0]        mag_b;
   logic signed [SAMP_W-1:0] wave;
   logic [SAMP_W-1:0]        scaled;

   lfo_phase_acc #(.FRAC_W(FRAC_W), .INT_W(INT_W), .VIEW_W(VIEW_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en   (strobe),
      .rate      (rate),
      .phase_view(phase_view)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q <= DEPTH_RST;
      end else if (strobe) begin
         depth_q <= depth;
      end
   end

   hsine_rom #(.IDX_W(IDX_W), .SAMP_W(SAMP_W)) u_rom (
      .idx_a(idx_a),
      .idx_b(idx_b),
      .mag_a(mag_a),
      .mag_b(mag_b)
   );

   lfo_interp #(.FRAC_W(FRAC_W), .IDX_W(IDX_W), .SAMP_W(SAMP_W)) u_interp (
      .whole(phase_view[VIEW_W-1:FRAC_W]),
      .frac (phase_view[FRAC_W-1:0]),
      .idx_a(idx_a),
      .idx_b(idx_b),
      .mag_a(mag_a),
      .mag_b(mag_b),
      .wave (wave)
   );

   lfo_depth_scale #(.SAMP_W(SAMP_W), .DEPTH_W(DEPTH_W)) u_scale (
      .wave  (wave),
      .depth (depth_q),
      .scaled(scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_out <= '0;
      end else begin
         mod_out <= scaled;
      end
   end
endmodule

// File: rtl/hsine_lfo_chk.sv
module hsine_lfo_chk #(
   parameter int FRAC_W  = 16,
   parameter int VIEW_W  = 26,
   parameter int SAMP_W  = 16,
   parameter int DEPTH_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               strobe,
   input logic [FRAC_W-1:0]  rate,
   input logic [DEPTH_W-1:0] depth,
   input logic [VIEW_W-1:0]  phase_view,
   input logic [DEPTH_W-1:0] depth_q,
   input logic [SAMP_W-1:0]  mod_out
);
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> phase_view == $past(phase_view) + VIEW_W'($past(rate))); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(phase_view) && $stable(depth_q)); // R3

   AST_DEPTH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> depth_q == $past(depth)); // R4

   AST_INT_LE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (mod_out >> (SAMP_W - DEPTH_W)) <= SAMP_W'($past(depth_q))); // R9

   AST_ZERO_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      depth_q == '0 |=> mod_out == '0); // R9
endmodule

bind hsine_lfo hsine_lfo_chk #(
   .FRAC_W (FRAC_W),
   .VIEW_W (VIEW_W),
   .SAMP_W (SAMP_W),
   .DEPTH_W(DEPTH_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .strobe    (strobe),
   .rate      (rate),
   .depth     (depth),
   .phase_view(phase_view),
   .depth_q   (depth_q),
   .mod_out   (mod_out)
);

// File: tb/hsine_lfo_tb.sv
module hsine_lfo_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strobe = 1'b0;
   logic [15:0] rate = '0;
   logic [7:0]  depth = '0;
   logic [15:0] mod_out;

   int n_vec = 0;
   int n_bad = 0;
   int tbl [512];
   logic [31:0] m_phase = '0;
   int m_depth = 13;
   int prev_exp = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hsine_lfo u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobe),
      .rate   (rate),
      .depth  (depth),
      .mod_out(mod_out)
   );

   function automatic int exp_mod(input logic [31:0] ph, input int d);
      int up;
      int f;
      int up1;
      longint s0;
      longint s1;
      longint a;
      longint w;
      int u;
      up  = int'(ph[31:16]);
      f   = int'(ph[15:0]);
      up1 = (up + 1) & 65535;
      s0  = longint'(tbl[up & 511]);
      s1  = longint'(tbl[up1 & 511]);
      if (((up >> 9) & 1) == 0) s0 = -s0;   // R6
      if (((up1 >> 9) & 1) == 0) s1 = -s1;  // R7
      a = s0 * longint'(65535 - f) + s1 * longint'(f);
      w = a >>> 16;                          // R8
      u = int'((w + 32768) & 65535);
      return (u * d) >> 8;                   // R9
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: mod_out=0x%04h expected 0x%04h (phase=0x%08h depth=%0d)",
                  tag, got, exp, m_phase, m_depth);
      end
   endtask

   // one strobed sample; tag "" lets the fraction pick R5 or R7
   task automatic tick(input logic [15:0] r, input logic [7:0] d, input string tag);
      int e;
      string t;
      @(negedge clk);
      strobe = 1'b1;
      rate   = r;
      depth  = d;
      @(negedge clk);
      strobe = 1'b0;
      check("R10", int'(mod_out), prev_exp);
      m_phase = m_phase + {16'h0, r};
      m_depth = int'(d);
      e = exp_mod(m_phase, m_depth);
      t = tag;
      if (t == "") t = (m_phase[15:0] == 16'h0) ? "R5" : "R7";
      @(negedge clk);
      check(t, int'(mod_out), e);
      prev_exp = e;
   endtask

   task automatic idle_hold(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         strobe = 1'b0;
         rate   = 16'hFFFF;
         depth  = 8'(8'hA5 + c);
         @(negedge clk);
         check("R3", int'(mod_out), prev_exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 512; i++) begin
         tbl[i] = $rtoi(32767.0 * $sin(3.14159265358979323846 * real'(i) / 512.0) + 0.5);
      end
      depth = 8'hAA;
      repeat (3) @(negedge clk);
      check("R1", int'(mod_out), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      prev_exp = exp_mod(32'h0, 13);
      check("R1", int'(mod_out), 16'h0680);
      check("R1", int'(mod_out), prev_exp);
      idle_hold(4);

      // fraction alternates 0 / half: raw entries and second-sample path
      for (int n = 0; n < 64; n++) tick(16'h8000, 8'h80, "");
      // about one index step per tick across both polarities and wraps
      for (int n = 0; n < 1100; n++) tick(16'hFFFF, 8'hFF, "R6");
      // carry ripple with changing depth
      for (int n = 0; n < 300; n++) tick(16'h1234, 8'(n * 37), (n % 2 == 0) ? "R2" : "R4");
      // odd fractions stress interpolation rounding
      for (int n = 0; n < 200; n++) tick(16'h0777, 8'h40, "R8");
      for (int n = 0; n < 8; n++) tick(16'h3F01, 8'h00, "R9");
      for (int n = 0; n < 8; n++) tick(16'h3F01, 8'hFF, "R9");
      idle_hold(4);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule